// File: doc/BRIEF.md
# Serial Link Bit and Word Alignment Trainer

This controller trains a 7:1 serial receiver so that it samples every lane at a good point and on the right word boundary. It runs on the slow parallel clock. It looks only at the 7-bit word recovered from the clock lane. The data lanes are taken to be edge-aligned with the clock lane, so they share its delay and slip settings.

Training has two phases. In the first phase the block sweeps an input delay line upward, one tap at a time. At each tap it checks whether the sampled word stays steady, which gives the width of the stable window. It then walks the delay back to the middle of that window and raises bit lock. In the second phase it sends single-cycle word-slip requests until the clock-lane word reads 1100011. It then raises word lock and ready, and keeps watching the clock lane for a loss of alignment.

The deserialiser and the delay line sit outside this block. The block only sends them load, move, direction and slip commands.

Top module: `lvds_align_trainer`

## Requirements
- R1: While `sync_ready` is low, the block stays idle. From the first clock edge after `sync_ready` goes low, `bit_lock`, `word_lock` and `ready` are low. From the next cycle on, no delay or slip command is issued.
- R2: A sweep starts with a one-cycle `delay_load` pulse, which selects default tap 0. Each later tap is reached by a one-cycle `delay_move` with `delay_dir`=1 (1 means one tap up, 0 means one tap down). A tap is judged from 16 samples taken after a 4-cycle settle, so upward moves are exactly 21 cycles apart.
- R3: A tap is valid when all 16 samples are identical. `window_size` reports the number of taps in the first contiguous run of valid taps. The sweep ends at the first invalid tap after that run, or at the top tap (127).
- R4: After the sweep, the delay steps down one tap per cycle to the first valid tap plus floor(width/2). `bit_lock` rises when the delay reaches that tap.
- R5: If a full sweep finds no valid tap, `bit_lock` stays low and a new sweep starts with another `delay_load` pulse.
- R6: Word alignment starts only after bit lock. The block waits 4 cycles, then compares the word with 7'b1100011 (value 0x63). On a mismatch it issues a one-cycle `word_slip` and waits again. On a match, `word_lock` and `ready` rise together.
- R7: If the word still mismatches after 7 slips, `bit_lock` drops and training restarts with a `delay_load` pulse.
- R8: While `ready` is high, 8 consecutive cycles of a word other than 0x63 drop `ready` and both lock flags and start retraining. A run of 7 or fewer mismatches changes nothing.
- R9: `ready` is never high unless `bit_lock` and `word_lock` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel (slow) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_ready | input | 1 | Upstream clocking is stable; training may run |
| rx_word | input | 7 | Deserialised clock-lane word |
| delay_load | output | 1 | Pulse: set the delay line to its default tap |
| delay_move | output | 1 | Pulse: move the delay line one tap |
| delay_dir | output | 1 | Move direction, 1 = up, 0 = down |
| word_slip | output | 1 | Pulse: shift the deserialiser word boundary by one bit |
| window_size | output | 8 | Width in taps of the measured stable window |
| bit_lock | output | 1 | Sampling point centred |
| word_lock | output | 1 | Word boundary found |
| ready | output | 1 | Lanes may be used |

## Verification
The hardest situations to reach from the ports are the failures: a sweep that finds no stable tap at all, and a stable window whose word never becomes the training pattern under any slip. The bench's behavioural lane hides a bit offset and a valid tap range. It can place the range beyond the last tap, and it can replace the in-window word with a steady value that is not a rotation of the pattern. Each of these forces a restart path. It can also corrupt the word for exactly 7 or exactly 8 cycles to probe the loss threshold.

// File: rtl/align_pkg.sv
package align_pkg;
  typedef enum logic [2:0] {
    TR_IDLE,
    TR_LOAD,
    TR_SCAN,
    TR_UP,
    TR_DOWN,
    TR_SWAIT,
    TR_SLIP,
    TR_LOCK
  } tr_state_e;
endpackage

// File: rtl/lane_stab_mon.sv
module lane_stab_mon #(
  parameter int W      = 7,
  parameter int SETTLE = 4,
  parameter int OBS    = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  logic [W-1:0] word,
  output logic         done,
  output logic         stable
);
  localparam int LAST = SETTLE + OBS - 1;
  localparam int CW   = $clog2(LAST + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  ref_q, ref_d;
  logic          ok_q, ok_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    ref_d  = ref_q;
    ok_d   = ok_q;
    if (abort) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(SETTLE)) begin
        ref_d = word;
        ok_d  = 1'b1;
      end else if (cnt_q > CW'(SETTLE)) begin
        ok_d = ok_q & (word == ref_q);
      end
      if (cnt_q == CW'(LAST)) busy_d = 1'b0;
      else                    cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ref_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      ref_q  <= ref_d;
      ok_q   <= ok_d;
    end
  end

  assign done   = busy_q && (cnt_q == CW'(LAST));
  assign stable = ok_q && (word == ref_q);

  // R3: each judgement ends the observation, so done never repeats back to back
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/delay_tap_track.sv
module delay_tap_track #(
  parameter int NUM_TAPS = 128,
  parameter int DEF_TAP  = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic                        move,
  input  logic                        dir,
  output logic [$clog2(NUM_TAPS)-1:0] tap
);
  localparam int TAP_W = $clog2(NUM_TAPS);

  logic [TAP_W-1:0] tap_q, tap_d;

  always_comb begin
    tap_d = tap_q;
    if (load)
      tap_d = TAP_W'(DEF_TAP);
    else if (move && dir && tap_q != TAP_W'(NUM_TAPS - 1))
      tap_d = tap_q + 1'b1;
    else if (move && !dir && tap_q != '0)
      tap_d = tap_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= TAP_W'(DEF_TAP);
    else        tap_q <= tap_d;
  end

  assign tap = tap_q;

  // R2: the sweep never asks the delay line to run past either end
  p_no_overrun_r2: assert property (@(posedge clk) disable iff (!rst_n)
    move |-> !((dir && tap_q == TAP_W'(NUM_TAPS - 1)) || (!dir && tap_q == '0)));
endmodule

// File: rtl/tap_window_rec.sv
module tap_window_rec #(
  parameter int TAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic             valid,
  input  logic [TAP_W-1:0] tap,
  output logic [TAP_W-1:0] first,
  output logic [TAP_W:0]   len
);
  logic [TAP_W-1:0] first_q, first_d;
  logic [TAP_W:0]   len_q, len_d;

  always_comb begin
    first_d = first_q;
    len_d   = len_q;
    if (clear) begin
      first_d = '0;
      len_d   = '0;
    end else if (en && valid) begin
      if (len_q == '0) first_d = tap;
      len_d = len_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      len_q   <= '0;
    end else begin
      first_q <= first_d;
      len_q   <= len_d;
    end
  end

  assign first = first_q;
  assign len   = len_q;

  // R3: once a window has begun, its first tap is fixed until cleared
  p_first_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && valid && !clear && len_q != '0) |=> $stable(first_q));
endmodule

// File: rtl/lvds_align_trainer.sv
module lvds_align_trainer
  import align_pkg::*;
#(
  parameter int         WORD_W     = 7,
  parameter logic [6:0] TRAIN_WORD = 7'b1100011,
  parameter int         NUM_TAPS   = 128,
  parameter int         DEF_TAP    = 0,
  parameter int         SETTLE_CYC = 4,
  parameter int         OBS_CYC    = 16,
  parameter int         SLIP_WAIT  = 4,
  parameter int         MAX_SLIPS  = 7,
  parameter int         LOSS_CYC   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sync_ready,
  input  logic [WORD_W-1:0]             rx_word,
  output logic                          delay_load,
  output logic                          delay_move,
  output logic                          delay_dir,
  output logic                          word_slip,
  output logic [$clog2(NUM_TAPS):0]     window_size,
  output logic                          bit_lock,
  output logic                          word_lock,
  output logic                          ready
);
  localparam int TAP_W  = $clog2(NUM_TAPS);
  localparam int LEN_W  = TAP_W + 1;
  localparam int CMAX   = (SLIP_WAIT > LOSS_CYC) ? SLIP_WAIT : LOSS_CYC;
  localparam int CNT_W  = $clog2(CMAX + 1);
  localparam int SL_W   = $clog2(MAX_SLIPS + 1);
  localparam logic [WORD_W-1:0] PATTERN = WORD_W'(TRAIN_WORD);

  tr_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SL_W-1:0]   slip_q, slip_d;
  logic              bl_q, bl_d, wl_q, wl_d, rdy_q, rdy_d;
  logic [LEN_W-1:0]  wsz_q, wsz_d;

  logic              ld_c, mv_c, dir_c, slip_c, st_start, rec_clr, rec_en;
  logic              st_done, st_stable;
  logic [TAP_W-1:0]  tap, rec_first;
  logic [LEN_W-1:0]  rec_len, centre;
  logic              in_win, at_top, word_ok;

  lane_stab_mon #(.W(WORD_W), .SETTLE(SETTLE_CYC), .OBS(OBS_CYC)) u_stab (
    .clk(clk), .rst_n(rst_n), .start(st_start), .abort(!sync_ready),
    .word(rx_word), .done(st_done), .stable(st_stable)
  );

  delay_tap_track #(.NUM_TAPS(NUM_TAPS), .DEF_TAP(DEF_TAP)) u_tap (
    .clk(clk), .rst_n(rst_n), .load(ld_c), .move(mv_c), .dir(dir_c), .tap(tap)
  );

  tap_window_rec #(.TAP_W(TAP_W)) u_win (
    .clk(clk), .rst_n(rst_n), .clear(rec_clr), .en(rec_en), .valid(st_stable),
    .tap(tap), .first(rec_first), .len(rec_len)
  );

  assign in_win  = (rec_len != '0);
  assign at_top  = (tap == TAP_W'(NUM_TAPS - 1));
  assign centre  = {1'b0, rec_first} + (rec_len >> 1);
  assign word_ok = (rx_word == PATTERN);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    slip_d   = slip_q;
    bl_d     = bl_q;
    wl_d     = wl_q;
    rdy_d    = rdy_q;
    wsz_d    = wsz_q;
    ld_c     = 1'b0;
    mv_c     = 1'b0;
    dir_c    = 1'b0;
    slip_c   = 1'b0;
    st_start = 1'b0;
    rec_clr  = 1'b0;
    rec_en   = 1'b0;
    if (!sync_ready) begin
      state_d = TR_IDLE;
      bl_d    = 1'b0;
      wl_d    = 1'b0;
      rdy_d   = 1'b0;
    end else begin
      unique case (state_q)
        TR_IDLE: state_d = TR_LOAD;
        TR_LOAD: begin
          ld_c     = 1'b1;
          rec_clr  = 1'b1;
          st_start = 1'b1;
          state_d  = TR_SCAN;
        end
        TR_SCAN: begin
          if (st_done) begin
            rec_en = 1'b1;
            if ((in_win && !st_stable) || at_top)
              state_d = (in_win || st_stable) ? TR_DOWN : TR_LOAD;
            else
              state_d = TR_UP;
          end
        end
        TR_UP: begin
          mv_c     = 1'b1;
          dir_c    = 1'b1;
          st_start = 1'b1;
          state_d  = TR_SCAN;
        end
        TR_DOWN: begin
          wsz_d = rec_len;
          if ({1'b0, tap} > centre) begin
            mv_c = 1'b1;
          end else begin
            bl_d    = 1'b1;
            cnt_d   = '0;
            slip_d  = '0;
            state_d = TR_SWAIT;
          end
        end
        TR_SWAIT: begin
          if (cnt_q == CNT_W'(SLIP_WAIT - 1)) begin
            cnt_d = '0;
            if (word_ok) begin
              wl_d    = 1'b1;
              rdy_d   = 1'b1;
              state_d = TR_LOCK;
            end else if (slip_q == SL_W'(MAX_SLIPS)) begin
              bl_d    = 1'b0;
              state_d = TR_LOAD;
            end else begin
              state_d = TR_SLIP;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        TR_SLIP: begin
          slip_c  = 1'b1;
          slip_d  = slip_q + 1'b1;
          cnt_d   = '0;
          state_d = TR_SWAIT;
        end
        TR_LOCK: begin
          if (!word_ok) begin
            if (cnt_q == CNT_W'(LOSS_CYC - 1)) begin
              cnt_d   = '0;
              bl_d    = 1'b0;
              wl_d    = 1'b0;
              rdy_d   = 1'b0;
              state_d = TR_LOAD;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            cnt_d = '0;
          end
        end
        default: state_d = TR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TR_IDLE;
      cnt_q   <= '0;
      slip_q  <= '0;
      bl_q    <= 1'b0;
      wl_q    <= 1'b0;
      rdy_q   <= 1'b0;
      wsz_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      slip_q  <= slip_d;
      bl_q    <= bl_d;
      wl_q    <= wl_d;
      rdy_q   <= rdy_d;
      wsz_q   <= wsz_d;
    end
  end

  assign delay_load  = ld_c;
  assign delay_move  = mv_c;
  assign delay_dir   = dir_c;
  assign word_slip   = slip_c;
  assign window_size = wsz_q;
  assign bit_lock    = bl_q;
  assign word_lock   = wl_q;
  assign ready       = rdy_q;

  // R1: a low sync_ready clears every flag by the next edge
  p_idle_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ready |=> (!bit_lock && !word_lock && !ready));

  // R1: a second idle cycle issues no commands
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_ready && $past(!sync_ready)) |-> (!delay_load && !delay_move && !word_slip));

  // R4: bit lock rises only with the delay sitting on the window centre
  p_centre_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_lock) |-> ({1'b0, tap} == centre));

  // R6: slips happen only during word alignment
  p_slip_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_slip |-> (bit_lock && !word_lock));

  // R6: a slip request lasts a single cycle
  p_slip_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_slip |=> !word_slip);

  // R6: word lock and ready rise together
  p_lock_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $rose(word_lock));

  // R9: ready implies both locks
  p_ready_locks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (bit_lock && word_lock));
endmodule

// File: tb/tb_lvds_align_trainer.sv
module tb_lvds_align_trainer;
  localparam logic [6:0] PAT = 7'b1100011;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_ready;
  logic [6:0] rx_word;
  logic       delay_load, delay_move, delay_dir, word_slip;
  logic [7:0] window_size;
  logic       bit_lock, word_lock, ready;

  always #2 clk = ~clk;

  lvds_align_trainer dut (
    .clk(clk), .rst_n(rst_n), .sync_ready(sync_ready), .rx_word(rx_word),
    .delay_load(delay_load), .delay_move(delay_move), .delay_dir(delay_dir),
    .word_slip(word_slip), .window_size(window_size), .bit_lock(bit_lock),
    .word_lock(word_lock), .ready(ready)
  );

  // behavioural lane: hidden offset and valid tap range
  int lo, hi, off_cfg;
  bit bad, corrupt;
  int lane_tap = 0;
  int slips_total = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (delay_load)      lane_tap <= 0;
    else if (delay_move) lane_tap <= delay_dir ? lane_tap + 1 : lane_tap - 1;
    if (word_slip) slips_total <= slips_total + 1;
  end

  function automatic int cur_off();
    return (((off_cfg - slips_total) % 7) + 7) % 7;
  endfunction

  function automatic logic [6:0] rot(input logic [6:0] p, input int e);
    logic [13:0] d;
    d = {p, p} << e;
    return d[13:7];
  endfunction

  always_comb begin
    if (lane_tap >= lo && lane_tap <= hi) begin
      if (bad)          rx_word = 7'h55;
      else if (corrupt) rx_word = ~rot(PAT, cur_off());
      else              rx_word = rot(PAT, cur_off());
    end else begin
      rx_word = 7'((cyc * 37) & 127);
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { int win; int centre; int slips; } exp_t;
  exp_t q[$];

  task automatic expect_train(input int l, input int h);
    exp_t e;
    e.win    = h - l + 1;
    e.centre = l + (h - l + 1) / 2;
    e.slips  = cur_off();
    q.push_back(e);
  endtask

  int  mcyc = 0, prev_up = -1, lock_tap = 0, slip_cnt = 0, loads = 0;
  bit  pbl = 0, prdy = 0, gap_done = 0, bl_seen = 0;

  always @(negedge clk) begin
    mcyc++;
    if (delay_load) begin prev_up = -1; gap_done = 0; loads++; end
    if (delay_move && delay_dir) begin
      if (prev_up >= 0 && !gap_done) begin
        chk("R2 up-move spacing", mcyc - prev_up, 21);
        gap_done = 1;
      end
      prev_up = mcyc;
    end
    if (word_slip) slip_cnt++;
    if (bit_lock && !pbl) begin lock_tap = lane_tap; slip_cnt = 0; bl_seen = 1; end
    if (ready && !prdy) begin
      if (q.size() == 0) chk("R6 unexpected ready", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk("R3 window_size", int'(window_size), e.win);
        chk("R4 centre tap", lock_tap, e.centre);
        chk("R6 slip count", slip_cnt, e.slips);
        chk("R6 word_lock with ready", int'(word_lock), 1);
        chk("R9 bit_lock with ready", int'(bit_lock), 1);
      end
    end
    pbl  = bit_lock;
    prdy = ready;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic wait_ready(input string req);
    int t = 0;
    while (!ready && t < 20000) begin @(negedge clk); t++; end
    chk(req, int'(ready), 1);
  endtask

  task automatic go_idle();
    @(negedge clk);
    sync_ready = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; sync_ready = 1'b0;
    lo = 10; hi = 29; off_cfg = 3; bad = 0; corrupt = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", int'(ready), 0);
    chk("R1 reset bit_lock", int'(bit_lock), 0);
    chk("R1 reset window_size", int'(window_size), 0);
    rst_n = 1'b1;
    begin
      int cmds = 0;
      repeat (20) begin
        @(negedge clk);
        cmds += int'(delay_load) + int'(delay_move) + int'(word_slip);
      end
      chk("R1 no commands while idle", cmds, 0);
    end

    // case A: mid-range window, offset 3
    expect_train(lo, hi);
    sync_ready = 1'b1;
    wait_ready("R6 case A ready");

    // R8: 7 mismatches tolerated
    repeat (3) @(negedge clk);
    corrupt = 1;
    repeat (7) @(negedge clk);
    corrupt = 0;
    repeat (3) @(negedge clk);
    chk("R8 seven mismatches keep ready", int'(ready), 1);
    // R8: 8 mismatches drop and retrain
    expect_train(lo, hi);
    corrupt = 1;
    repeat (8) @(negedge clk);
    chk("R8 eight mismatches drop ready", int'(ready), 0);
    chk("R8 eight mismatches drop bit_lock", int'(bit_lock), 0);
    corrupt = 0;
    wait_ready("R8 retrain ready");

    // R1/R9-style idle drop, then case B at the top of the range
    go_idle();
    chk("R1 sync drop clears ready", int'(ready), 0);
    lo = 100; hi = 127; off_cfg = cur_off() + 6;
    expect_train(lo, hi);
    sync_ready = 1'b1;
    repeat (300) @(negedge clk);
    go_idle();
    begin
      int cmds = 0;
      repeat (10) begin
        @(negedge clk);
        cmds += int'(delay_load) + int'(delay_move) + int'(word_slip);
      end
      chk("R1 mid-sweep drop quiet", cmds, 0);
      chk("R1 mid-sweep drop bit_lock", int'(bit_lock), 0);
    end
    sync_ready = 1'b1;
    wait_ready("R3 top-edge window ready");

    // case C: window starting at the default tap
    go_idle();
    lo = 0; hi = 4; off_cfg = cur_off() + 1;
    expect_train(lo, hi);
    sync_ready = 1'b1;
    wait_ready("R4 bottom-edge window ready");

    // R5: no valid tap anywhere
    go_idle();
    lo = 200; hi = 210;
    loads = 0; bl_seen = 0;
    sync_ready = 1'b1;
    begin
      int t = 0;
      while (loads < 3 && t < 12000) begin @(negedge clk); t++; end
    end
    chk("R5 rescans issued", (loads >= 3) ? 1 : 0, 1);
    chk("R5 no bit_lock without window", int'(bl_seen), 0);

    // R7: stable window whose word never matches
    go_idle();
    lo = 40; hi = 50; bad = 1;
    sync_ready = 1'b1;
    begin
      int t = 0;
      while (!bit_lock && t < 5000) begin @(negedge clk); t++; end
      t = 0;
      while (bit_lock && t < 500) begin @(negedge clk); t++; end
    end
    chk("R7 slips before giving up", slip_cnt, 7);
    chk("R7 restart load pulse", int'(delay_load), 1);
    bad = 0;
    expect_train(lo, hi);
    wait_ready("R7 recovery ready");

    repeat (5) @(negedge clk);
    chk("R6 scoreboard drained", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule